// File: doc/BRIEF.md
# Light Pen Address Capture with Status Byte

This block sits beside a character-based display timing generator. When an external light pen reports a hit, the block records the display memory address the scan is at, and holds it in two read-only bytes for the host. It also builds a status byte with three flags that the host can read. The first flag reports a pending capture. The second reports a pending update strobe. The third is the live vertical blanking state.

The pen input is asynchronous. It passes through a synchroniser into a three-state tracker with the states PEN_IDLE, PEN_ARMED and PEN_HELD. The transitions are:
- PEN_IDLE to PEN_ARMED when the synchronised pen goes high.
- PEN_ARMED to PEN_HELD on the first character tick, which is also the cycle that captures.
- PEN_HELD to PEN_IDLE when the synchronised pen goes low.

The host interface reports each register access with a pulse, a read/write flag and a 5-bit register index. The block watches these reports to clear the flags, and each flag has its own set event and its own clearing access.

Top module: `pen_latch_status`

## Requirements
- R1: After reset, both captured address bytes are 0, and status bits 7 and 6 are 0.
- R2: A rising pen strobe is captured on the first clock edge with `char_tick` high, counted after the pen tracker has armed. Arming takes two synchroniser stages plus one cycle. `pen_addr_hi[5:0]` then holds `mem_addr[13:8]` with bits 7:6 at 0, and `pen_addr_lo` holds `mem_addr[7:0]`. Both update on the capturing edge.
- R3: While the pen strobe stays high after a capture, further character ticks leave the captured address unchanged. The strobe must be seen low before another capture can happen.
- R4: Status bit 6 is set on the capturing edge. It is cleared by a host read of register index 16 or 17. A host write to those indices leaves it unchanged.
- R5: Status bit 7 is set on the edge after an `update_strobe` cycle. It is cleared by a host read or write of register index 31.
- R6: Status bit 5 equals `vblank` in the same cycle, with no register delay.
- R7: Status bits 4 to 0 always read 0.
- R8: A capture while bit 6 is already set overwrites both address bytes, and bit 6 stays set.
- R9: If a set event and a clearing access for the same flag arrive in the same cycle, the flag ends up set.
- R10: Host accesses to any index other than 16, 17 and 31, and accesses with `host_acc` low, do not change bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_tick | input | 1 | Character clock enable |
| mem_addr | input | 14 | Current display memory address |
| vblank | input | 1 | High while the scan is in vertical blanking |
| pen_strobe | input | 1 | Asynchronous light pen hit |
| update_strobe | input | 1 | One-cycle update event |
| host_acc | input | 1 | Host register access pulse |
| host_rd | input | 1 | 1 = read, 0 = write for the current access |
| host_idx | input | 5 | Register index of the current access |
| pen_addr_hi | output | 8 | Captured address, upper 6 bits in [5:0] |
| pen_addr_lo | output | 8 | Captured address, lower 8 bits |
| status | output | 8 | {update flag, pen flag, vblank, 5'b0} |

## Verification
The bench checks each result at the time it is due:
- **Flags (bits 7 and 6):** the flag registers react one edge after the access or strobe, so the bench applies inputs just after an edge and compares just after the following edge.
- **Vertical blanking (bit 5):** this bit is combinational, so it is compared in the same sample as the input that drove it.
- **Pen capture:** the path takes three edges to arm, so the bench holds `char_tick` low for exactly those edges and first checks that nothing was captured. It then raises `char_tick` for one edge and expects both address bytes and bit 6 right after it.
- **Random phase:** the bench keeps a flag model that it steps with the same one-edge latency, and compares against it after every edge.

// File: rtl/lpen_pkg.sv
package lpen_pkg;
    typedef enum logic [1:0] {
        PEN_IDLE  = 2'd0,
        PEN_ARMED = 2'd1,
        PEN_HELD  = 2'd2
    } pen_state_e;

    localparam int unsigned FLAG_PEN = 0;
    localparam int unsigned FLAG_UPD = 1;
    localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/lpen_sync.sv
module lpen_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpen_capture.sv
module lpen_capture
    import lpen_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pen_s,
    input  logic              char_tick,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_pulse
);
    pen_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEN_IDLE:  if (pen_s)     state_d = PEN_ARMED;
            PEN_ARMED: if (char_tick) state_d = PEN_HELD;
            PEN_HELD:  if (!pen_s)    state_d = PEN_IDLE;
            default:                  state_d = PEN_IDLE;
        endcase
    end

    always_comb begin
        cap_pulse = (state_q == PEN_ARMED) && char_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         cap_addr <= '0;
        else if (cap_pulse) cap_addr <= mem_addr;
    end

    // R2: a seen rising pen arms the tracker on the next edge
    a_r2_arm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PEN_IDLE && pen_s) |=> (state_q == PEN_ARMED));
    // R2: the capture takes the address present on the capturing edge
    a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (cap_addr == $past(mem_addr)));
    // R3: without a capture the held address does not move
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse |=> $stable(cap_addr));
endmodule

// File: rtl/lpen_flags.sv
module lpen_flags
    import lpen_pkg::*;
#(
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned IDX_PEN_HI = 16,
    parameter int unsigned IDX_PEN_LO = 17,
    parameter int unsigned IDX_UPD    = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pulse,
    input  logic             update_strobe,
    input  logic             host_acc,
    input  logic             host_rd,
    input  logic [IDX_W-1:0] host_idx,
    output logic             pen_full,
    output logic             upd_ready
);
    logic [NUM_FLAGS-1:0] set_v, clr_v, flag_q;

    always_comb begin
        set_v[FLAG_PEN] = cap_pulse;
        clr_v[FLAG_PEN] = host_acc && host_rd &&
                          ((host_idx == IDX_W'(IDX_PEN_HI)) ||
                           (host_idx == IDX_W'(IDX_PEN_LO)));
        set_v[FLAG_UPD] = update_strobe;
        clr_v[FLAG_UPD] = host_acc && (host_idx == IDX_W'(IDX_UPD));
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         flag_q[g] <= 1'b0;
            else if (set_v[g])  flag_q[g] <= 1'b1;
            else if (clr_v[g])  flag_q[g] <= 1'b0;
        end
    end

    assign pen_full  = flag_q[FLAG_PEN];
    assign upd_ready = flag_q[FLAG_UPD];

    // R4 / R9: a capture always leaves the pen flag set
    a_r4_pen_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> pen_full);
    // R4: a read of a pen index clears the flag when no capture competes
    a_r4_pen_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_acc && host_rd && (host_idx == IDX_W'(IDX_PEN_LO)) && !cap_pulse)
        |=> !pen_full);
    // R10: the pen flag holds when neither event is present
    a_r10_pen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_pulse && !host_acc) |=> $stable(pen_full));
    // R5 / R9: the update strobe always leaves its flag set
    a_r5_upd_set: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> upd_ready);
    // R5: any access to the update index clears the flag without a strobe
    a_r5_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_acc && (host_idx == IDX_W'(IDX_UPD)) && !update_strobe) |=> !upd_ready);
endmodule

// File: rtl/pen_latch_status.sv
module pen_latch_status #(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDX_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_tick,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              vblank,
    input  logic              pen_strobe,
    input  logic              update_strobe,
    input  logic              host_acc,
    input  logic              host_rd,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [7:0]        pen_addr_hi,
    output logic [7:0]        pen_addr_lo,
    output logic [7:0]        status
);
    localparam int unsigned HI_W  = ADDR_W - 8;
    localparam int unsigned PAD_W = 8 - HI_W;

    logic              pen_s, cap_pulse, pen_full, upd_ready;
    logic [ADDR_W-1:0] cap_addr;

    lpen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pen_strobe), .q_sync(pen_s)
    );

    lpen_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .pen_s(pen_s), .char_tick(char_tick),
        .mem_addr(mem_addr), .cap_addr(cap_addr), .cap_pulse(cap_pulse)
    );

    lpen_flags #(.IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .cap_pulse(cap_pulse),
        .update_strobe(update_strobe), .host_acc(host_acc),
        .host_rd(host_rd), .host_idx(host_idx),
        .pen_full(pen_full), .upd_ready(upd_ready)
    );

    always_comb begin
        pen_addr_hi = {{PAD_W{1'b0}}, cap_addr[ADDR_W-1:8]};
        pen_addr_lo = cap_addr[7:0];
        status      = {upd_ready, pen_full, vblank, 5'b00000};
    end

    // R7: low status bits are never driven high
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[4:0] == 5'd0);
endmodule

// File: tb/tb_pen_latch_status.sv
module tb_pen_latch_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_tick = 1'b0;
    logic [13:0] mem_addr = '0;
    logic       vblank = 1'b0;
    logic       pen_strobe = 1'b0;
    logic       update_strobe = 1'b0;
    logic       host_acc = 1'b0;
    logic       host_rd = 1'b0;
    logic [4:0] host_idx = '0;
    logic [7:0] pen_addr_hi, pen_addr_lo, status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        exp_pen = 1'b0;
    logic        exp_upd = 1'b0;
    logic [13:0] exp_addr = '0;

    always #5 clk = ~clk;

    pen_latch_status dut (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .mem_addr(mem_addr),
        .vblank(vblank), .pen_strobe(pen_strobe), .update_strobe(update_strobe),
        .host_acc(host_acc), .host_rd(host_rd), .host_idx(host_idx),
        .pen_addr_hi(pen_addr_hi), .pen_addr_lo(pen_addr_lo), .status(status)
    );

    function automatic logic nxt(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    function automatic logic [7:0] exp_status();
        return {exp_upd, exp_pen, vblank, 5'b00000};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag);
        logic [7:0] eh, el, es;
        eh = {2'b00, exp_addr[13:8]};
        el = exp_addr[7:0];
        es = exp_status();
        checks++;
        if (status !== es || pen_addr_hi !== eh || pen_addr_lo !== el) begin
            failures++;
            $display("FAIL %s: status=%02h hi=%02h lo=%02h expected status=%02h hi=%02h lo=%02h",
                     tag, status, pen_addr_hi, pen_addr_lo, es, eh, el);
        end
    endtask

    task automatic idle_host();
        host_acc = 1'b0; host_rd = 1'b0; host_idx = '0; update_strobe = 1'b0;
    endtask

    // Raise the pen, wait the three arming edges, then capture on one tick
    task automatic pen_capture(logic [13:0] a, bit clr_same);
        pen_strobe = 1'b1; char_tick = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R2 no capture before char tick");
        char_tick = 1'b1; mem_addr = a;
        if (clr_same) begin host_acc = 1'b1; host_rd = 1'b1; host_idx = 5'd16; end
        tick();
        exp_addr = a; exp_pen = 1'b1;
        idle_host(); char_tick = 1'b0;
    endtask

    task automatic pen_release();
        pen_strobe = 1'b0;
        for (int i = 0; i < 4; i++) tick();
    endtask

    initial begin
        void'($urandom(32'd4242));
        vblank = 1'b1;
        tick(); tick();
        chk("R1 reset state / R6 vblank");
        rst_n = 1'b1;
        tick();
        chk("R1 after reset release / R7 low bits");

        pen_capture(14'h2A5C, 1'b0);
        chk("R2 R4 capture 2A5C sets bit6");

        char_tick = 1'b1; mem_addr = 14'h1111;
        for (int i = 0; i < 3; i++) tick();
        char_tick = 1'b0;
        chk("R3 held strobe does not recapture");

        host_acc = 1'b1; host_rd = 1'b0; host_idx = 5'd16; tick(); idle_host();
        chk("R4 write to index 16 leaves bit6");
        host_acc = 1'b1; host_rd = 1'b1; host_idx = 5'd17; tick(); idle_host();
        exp_pen = 1'b0;
        chk("R4 read of index 17 clears bit6");

        pen_release();
        pen_capture(14'h3FFF, 1'b1);
        chk("R9 capture beats read of index 16");

        pen_release();
        pen_capture(14'h0001, 1'b0);
        chk("R8 recapture overwrites with bit6 set");
        pen_release();

        vblank = 1'b0;
        update_strobe = 1'b1; tick(); idle_host(); exp_upd = 1'b1;
        chk("R5 update strobe sets bit7 / R6 vblank low");
        host_acc = 1'b1; host_rd = 1'b0; host_idx = 5'd30; tick(); idle_host();
        chk("R10 access to index 30 ignored");
        update_strobe = 1'b1; host_acc = 1'b1; host_rd = 1'b0; host_idx = 5'd31;
        tick(); idle_host();
        chk("R9 update strobe beats write of index 31");
        host_acc = 1'b1; host_rd = 1'b0; host_idx = 5'd31; tick(); idle_host();
        exp_upd = 1'b0;
        chk("R5 write of index 31 clears bit7");
        update_strobe = 1'b1; tick(); idle_host(); exp_upd = 1'b1;
        host_acc = 1'b1; host_rd = 1'b1; host_idx = 5'd31; tick(); idle_host();
        exp_upd = 1'b0;
        chk("R5 read of index 31 clears bit7");
        host_acc = 1'b0; host_rd = 1'b1; host_idx = 5'd17; tick(); idle_host();
        chk("R10 index 17 without access pulse ignored");

        // Random phase with the pen at rest
        for (int n = 0; n < 600; n++) begin
            logic pclr, uclr;
            update_strobe = ($urandom % 4) == 0;
            host_acc  = ($urandom % 2) == 0;
            host_rd   = ($urandom % 2) == 0;
            case ($urandom % 4)
                0: host_idx = 5'd16;
                1: host_idx = 5'd17;
                2: host_idx = 5'd31;
                default: host_idx = 5'($urandom);
            endcase
            vblank    = ($urandom % 2) == 0;
            char_tick = ($urandom % 2) == 0;
            mem_addr  = 14'($urandom);
            pclr = host_acc && host_rd && (host_idx == 5'd16 || host_idx == 5'd17);
            uclr = host_acc && (host_idx == 5'd31);
            tick();
            exp_pen = nxt(exp_pen, 1'b0, pclr);
            exp_upd = nxt(exp_upd, update_strobe, uclr);
            chk("R4 R5 R6 R10 random flags");
            if (n % 50 == 0) begin
                idle_host(); char_tick = 1'b0;
                pen_capture(14'($urandom), 1'b0);
                chk("R2 R8 random capture");
                pen_release();
                chk("R3 release holds address");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule